// File: doc/BRIEF.md
# Recirculating Shift-Register Word Store

This block is a small memory of four 2-bit words. It holds no addressable cells. Each data bit has its own serial shift register of depth four, and every register shifts on every clock edge. When nothing is being written, the bit leaving the last stage goes back into the first stage, so each word travels round its loop and comes back to the serial port every four cycles.

A free-running slot counter gives the relative address of the word now at the serial port. A comparator checks it against the requested address. A buffer register sits between the user and the loops. It can be loaded from the data inputs. It can capture the word at the port when that word's slot comes round. It can also supply the bits that replace the word at the port in place of the recirculated bits. Addresses are relative: an address means whichever word passes the port when the counter shows that value.

A decoder picks one action for each cycle from the three requests, the match flag and the buffer contents. The block is used by holding the address and a request for up to four cycles, until the slot comes round.

Top module: `recirc_word_store`

## Requirements
- R1: A synchronous active-high reset clears the slot counter, the buffer register and every storage bit to zero, so a fetch from any address after reset returns 0.
- R2: The slot counter `slot_q` advances by one on every clock edge not in reset and wraps from 3 to 0.
- R3: `slot_hit` is high exactly when `slot_q` equals `addr`.
- R4: When `ld_buf` is high, the buffer takes `din` at the next edge, whatever the other requests and the match flag are.
- R5: When `fetch_req` is high, `ld_buf` is low and `slot_hit` is high, the buffer takes the word stored at `addr` at the next edge. Bit i of a word is kept in lane i and appears as bit i of `buf_q`.
- R6: When `fetch_req` is high, `ld_buf` is low and `slot_hit` is low, the buffer keeps its value.
- R7: When `store_req` is high, `ld_buf` and `fetch_req` are low and `slot_hit` is high, the buffer contents replace the word at `addr` and its old value is lost. The other three words are not changed and the buffer keeps its value.
- R8: When no request is high, the buffer keeps its value and all four stored words keep circulating without loss, for any number of cycles.
- R9: Requests are ranked: load over fetch, and fetch over store. A store is suppressed in any cycle where load or fetch is high.
- R10: Holding `fetch_req` for four consecutive cycles at a fixed address always returns the last value stored at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the loops shift on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_buf | input | 1 | Load the buffer from `din` |
| fetch_req | input | 1 | Capture the addressed word into the buffer when its slot comes round |
| store_req | input | 1 | Write the buffer into the addressed word when its slot comes round |
| addr | input | 2 | Relative word address |
| din | input | 2 | Data word for a buffer load |
| buf_q | output | 2 | Buffer register contents |
| slot_q | output | 2 | Relative address of the word at the serial port |
| slot_hit | output | 1 | Slot counter equals `addr` |

## Verification
The bench builds the block with its default two-bit words and four-word depth. At that size the counter wraps every four cycles, so a few thousand random cycles put every request combination at every phase of the counter many times over. That covers overlapping requests, stores followed straight away by fetches, and long idle gaps. A bench model keeps the four words indexed by address. Directed runs add fetches from every address after reset, round trips of a store followed by a four-cycle fetch, and all three requests raised together.

// File: rtl/srs_pkg.sv
package srs_pkg;

    // Action chosen by the decoder for the coming edge.
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_LOAD,
        ACT_FETCH_WAIT,
        ACT_FETCH_GRAB,
        ACT_STORE_WAIT,
        ACT_STORE_WRITE
    } srs_act_e;

    // Next-value source of the buffer register.
    typedef enum logic [1:0] {
        BSRC_HOLD,
        BSRC_DIN,
        BSRC_SERIAL
    } srs_bsrc_e;

endpackage

// File: rtl/srs_slot_ctr.sv
module srs_slot_ctr #(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] slot,
    output logic          hit
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + AW'(1);
    end

    assign hit = (slot == addr);
endmodule

// File: rtl/srs_lane.sv
module srs_lane #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic new_bit,
    output logic ser_out
);
    logic [DEPTH-1:0] stages;
    logic             ser_in;

    // 2:1 selector at the serial input.
    assign ser_in  = wr_en ? new_bit : stages[DEPTH-1];
    assign ser_out = stages[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst)
            stages <= '0;
        else
            stages <= {stages[DEPTH-2:0], ser_in};
    end
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
    import srs_pkg::*;
(
    input  logic      ld_buf,
    input  logic      fetch_req,
    input  logic      store_req,
    input  logic      hit,
    output srs_act_e  act,
    output srs_bsrc_e bsrc,
    output logic      wr_en
);
    // Action selection with ranking load > fetch > store.
    always_comb begin
        if (ld_buf)
            act = ACT_LOAD;
        else if (fetch_req)
            act = hit ? ACT_FETCH_GRAB : ACT_FETCH_WAIT;
        else if (store_req)
            act = hit ? ACT_STORE_WRITE : ACT_STORE_WAIT;
        else
            act = ACT_IDLE;
    end

    // Per-action outputs.
    always_comb begin
        bsrc  = BSRC_HOLD;
        wr_en = 1'b0;
        unique case (act)
            ACT_IDLE:        ;
            ACT_LOAD:        bsrc = BSRC_DIN;
            ACT_FETCH_WAIT:  ;
            ACT_FETCH_GRAB:  bsrc = BSRC_SERIAL;
            ACT_STORE_WAIT:  ;
            ACT_STORE_WRITE: wr_en = 1'b1;
            default:         ;
        endcase
    end
endmodule

// File: rtl/srs_buffer.sv
module srs_buffer
    import srs_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  srs_bsrc_e    bsrc,
    input  logic [W-1:0] din,
    input  logic [W-1:0] ser,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else begin
            unique case (bsrc)
                BSRC_HOLD:   q <= q;
                BSRC_DIN:    q <= din;
                BSRC_SERIAL: q <= ser;
                default:     q <= q;
            endcase
        end
    end
endmodule

// File: rtl/recirc_word_store.sv
module recirc_word_store
    import srs_pkg::*;
#(
    parameter int W     = 2,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_buf,
    input  logic          fetch_req,
    input  logic          store_req,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  buf_q,
    output logic [AW-1:0] slot_q,
    output logic          slot_hit
);
    srs_act_e  act;
    srs_bsrc_e bsrc;
    logic      wr_en;
    logic [W-1:0] ser_word;

    srs_slot_ctr #(.DEPTH(DEPTH)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .addr (addr),
        .slot (slot_q),
        .hit  (slot_hit)
    );

    srs_ctrl u_ctrl (
        .ld_buf    (ld_buf),
        .fetch_req (fetch_req),
        .store_req (store_req),
        .hit       (slot_hit),
        .act       (act),
        .bsrc      (bsrc),
        .wr_en     (wr_en)
    );

    // One serial loop per data bit.
    for (genvar b = 0; b < W; b++) begin : g_lane
        srs_lane #(.DEPTH(DEPTH)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .new_bit (buf_q[b]),
            .ser_out (ser_word[b])
        );
    end

    srs_buffer #(.W(W)) u_buf (
        .clk  (clk),
        .rst  (rst),
        .bsrc (bsrc),
        .din  (din),
        .ser  (ser_word),
        .q    (buf_q)
    );
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
    parameter int W  = 2,
    parameter int AW = 2,
    parameter int DEPTH = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ld_buf,
    input logic          fetch_req,
    input logic          store_req,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  din,
    input logic [W-1:0]  buf_q,
    input logic [AW-1:0] slot_q,
    input logic          slot_hit
);
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(slot_q) == AW'(DEPTH - 1)) ? (slot_q == '0)
                                                     : (slot_q == $past(slot_q) + AW'(1)))); // R2

    AST_HIT_CMP: assert property (@(posedge clk) disable iff (rst)
        slot_hit == (slot_q == addr)); // R3

    AST_LOAD_DIN: assert property (@(posedge clk) disable iff (rst)
        ld_buf |=> buf_q == $past(din)); // R4

    AST_FETCH_MISS: assert property (@(posedge clk) disable iff (rst)
        (!ld_buf && fetch_req && !slot_hit) |=> $stable(buf_q)); // R6

    AST_STORE_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
        (!ld_buf && !fetch_req && store_req) |=> $stable(buf_q)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld_buf && !fetch_req && !store_req) |=> $stable(buf_q)); // R8
endmodule

bind recirc_word_store srs_chk #(.W(W), .AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_buf    (ld_buf),
    .fetch_req (fetch_req),
    .store_req (store_req),
    .addr      (addr),
    .din       (din),
    .buf_q     (buf_q),
    .slot_q    (slot_q),
    .slot_hit  (slot_hit)
);

// File: tb/sim_recirc_word_store.sv
`timescale 1ns/1ps
module sim_recirc_word_store;
    localparam int W = 2;
    localparam int DEPTH = 4;
    localparam int AW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_buf = 1'b0, fetch_req = 1'b0, store_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  buf_q;
    logic [AW-1:0] slot_q;
    logic          slot_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model
    logic [W-1:0]  mem [DEPTH];
    logic [W-1:0]  mbuf;
    logic [AW-1:0] mslot;

    always #2 clk = ~clk;

    recirc_word_store #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .ld_buf(ld_buf), .fetch_req(fetch_req),
        .store_req(store_req), .addr(addr), .din(din),
        .buf_q(buf_q), .slot_q(slot_q), .slot_hit(slot_hit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic l, input logic f, input logic s, input logic h);
        if (l) return "R4/R9";
        if (f) return h ? "R5/R9" : "R6";
        if (s) return h ? "R7" : "R8";
        return "R8";
    endfunction

    // One clock cycle, entered and left at a falling edge.
    task automatic cyc(input logic l, input logic f, input logic s,
                       input logic [AW-1:0] a, input logic [W-1:0] d);
        logic h;
        string t;
        ld_buf = l; fetch_req = f; store_req = s; addr = a; din = d;
        #1;
        h = (mslot == a);
        chk(slot_hit == h, "R3 hit", int'(slot_hit), int'(h));
        t = tag_of(l, f, s, h);
        if (l) mbuf = d;
        else if (f && h) mbuf = mem[a];
        else if (s && h) mem[a] = mbuf;
        mslot = mslot + AW'(1);
        @(negedge clk);
        chk(buf_q == mbuf, t, int'(buf_q), int'(mbuf));
        chk(slot_q == mslot, "R2 slot", int'(slot_q), int'(mslot));
    endtask

    task automatic fetch4(input logic [AW-1:0] a, input logic [W-1:0] exp, input string t);
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 1'b0, a, 2'b00);
        chk(buf_q == exp, t, int'(buf_q), int'(exp));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ref_w [DEPTH];
        void'($urandom(32'd385));
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        mbuf = '0; mslot = '0;
        repeat (3) @(negedge clk);
        chk(buf_q == '0, "R1 buffer reset", int'(buf_q), 0);
        chk(slot_q == '0, "R1 slot reset", int'(slot_q), 0);
        rst = 1'b0;

        // R1: all storage zero after reset
        for (int a = 0; a < DEPTH; a++) fetch4(AW'(a), '0, "R1 storage reset");

        // R10: store a distinct word at each address, idle, then fetch back
        for (int a = 0; a < DEPTH; a++) begin
            ref_w[a] = W'(3 - a);
            cyc(1'b1, 1'b0, 1'b0, AW'(a), ref_w[a]);
            for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 1'b1, AW'(a), 2'b00);
        end
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 2'b00);
        for (int k = 0; k < 9; k++) cyc(1'b0, 1'b0, 1'b0, 2'd0, 2'b00); // R8 idle circulation
        for (int a = DEPTH - 1; a >= 0; a--) fetch4(AW'(a), ref_w[a], "R10 round trip");

        // R9: all requests together keep storage intact, load wins
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b1, AW'(k), 2'b10);
        chk(buf_q == 2'b10, "R9 load wins", int'(buf_q), 2);
        // R9: fetch with store: fetch wins, no write
        cyc(1'b1, 1'b0, 1'b0, 2'd1, 2'b01);
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 1'b1, 2'd1, 2'b00);
        fetch4(2'd1, ref_w[1], "R9 store suppressed");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic l, f, s;
            l = ($urandom % 8) == 0;
            f = ($urandom % 4) == 0;
            s = ($urandom % 3) == 0;
            cyc(l, f, s, AW'($urandom), W'($urandom));
        end
        for (int a = 0; a < DEPTH; a++) begin
            logic [W-1:0] e;
            e = mem[a];
            fetch4(AW'(a), e, "R10 final");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule